// File: doc/BRIEF.md
# Uncore event counter unit

This block counts hardware events for a memory-side agent. It holds sixteen 48-bit counters. Each counter follows one line of a 256-wide event pulse vector, picked by an 8-bit code that software loads into a selector field. A counter advances only when the group enable bit and its own enable bit are both set, and only when its code is not the reserved "nothing selected" value.

Software reaches every register through a simple port: a one-cycle write strobe, a one-cycle read strobe, a 16-bit byte address and a 64-bit data path. Each counter occupies a 64-bit slot. When a counter rolls over from all ones to zero it sets its own overflow status bit. Software clears that bit by writing a 1 to it. A single interrupt line is raised whenever any status bit is set and its mask bit is clear.

Top module: `upmu_top`

## Requirements
- R1: After a cycle with `rst` high, every counter, per-counter enable, the group enable and every status bit read 0, the mask register reads 0xFFFF, and every selector field reads 0xFF.
- R2: Counter n lives at byte address 0x1F00 + 8*n. Its bits 47:0 are read and written directly, while bits 63:48 always read 0 and ignore written data.
- R3: Selector register k at address 0x1E80 + 4*k holds the codes of counters 4k..4k+3, and counter n uses bits [8*(n%4)+7 : 8*(n%4)] of register n/4.
- R4: A counter whose code is 0xFF never counts, whatever the event vector carries.
- R5: Bit 0 of the control register at 0x1E00 is the group enable. While it is 0, no counter advances.
- R6: Bit n of the enable register at 0x1E04 gates counter n. While it is 0, that counter holds its value.
- R7: An enabled counter with code c rises by exactly one in each cycle where `evt_pulse[c]` is 1.
- R8: An increment from 0xFFFF_FFFF_FFFF to 0 sets bit n of the status register at 0x0808.
- R9: Writing 1 to bit n of the clear register at 0x080C clears status bit n, while 0 bits leave status alone. If a wrap and a clear of the same bit fall in one cycle, the bit ends up set. The clear register reads 0.
- R10: `irq` is 1 exactly when some status bit n is 1 and bit n of the mask register at 0x0804 is 0.
- R11: A software write to a counter slot in the same cycle as an increment of that counter leaves the written value, and that cycle does not wrap or set status.
- R12: The register at 0x1CF0 reads the `VERSION` parameter and ignores writes.
- R13: Read data appears on `rdata` in the cycle after `rd_en`. It is 0 in any cycle not preceded by a read and for any unmapped address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 16 | Byte address of the access |
| wdata | input | 64 | Write data; 32-bit registers use bits 31:0 |
| evt_pulse | input | 256 | Event pulses, bit c is event code c |
| rdata | output | 64 | Read data, registered |
| irq | output | 1 | Overflow interrupt, level |

## Verification
The assertions assume that `wr_en` and `rd_en` are single-cycle strobes whose address is stable for that one cycle. They also assume that at most one register is written per cycle, and that `evt_pulse` is sampled level by level with no need for edges. The stimulus drives every input once per cycle at the falling edge and clears the strobes after each access. Random events are confined mostly to the low codes so that selected counters actually advance. Counter writes are often placed near the top value so that wraps, including a wrap colliding with a clear or a write, occur within the run.

// File: rtl/upmu_pkg.sv
package upmu_pkg;

    // register byte offsets; software depends on these
    localparam logic [15:0] OFS_MASK   = 16'h0804;
    localparam logic [15:0] OFS_STATUS = 16'h0808;
    localparam logic [15:0] OFS_CLEAR  = 16'h080C;
    localparam logic [15:0] OFS_VER    = 16'h1CF0;
    localparam logic [15:0] OFS_CTRL   = 16'h1E00;
    localparam logic [15:0] OFS_ENABLE = 16'h1E04;
    localparam logic [15:0] OFS_SEL0   = 16'h1E80;
    localparam logic [15:0] OFS_CNT0   = 16'h1F00;

    localparam int SEL_REG_BITS = 32;
    localparam int SLOT_BYTES   = 8;

    // address of the selector register that carries counter idx
    function automatic logic [15:0] sel_reg_addr(input int idx, input int per_reg);
        return OFS_SEL0 + 16'(4 * (idx / per_reg));
    endfunction

    // address of counter slot idx
    function automatic logic [15:0] cnt_slot_addr(input int idx);
        return OFS_CNT0 + 16'(SLOT_BYTES * idx);
    endfunction

    // one decoded register access
    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [15:0] addr;
        logic [63:0] data;
    } reg_access_t;

endpackage

// File: rtl/upmu_cfg.sv
module upmu_cfg
    import upmu_pkg::*;
#(
    parameter int NCTR = 16,
    parameter int EW   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_access_t       acc,
    output logic              grp_en,
    output logic [NCTR-1:0]   ctr_en,
    output logic [NCTR-1:0]   irq_mask,
    output logic [EW-1:0]     sel [NCTR]
);
    localparam int PER = SEL_REG_BITS / EW;

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_en   <= 1'b0;
            ctr_en   <= '0;
            irq_mask <= '1;
        end else if (acc.wr) begin
            case (acc.addr)
                OFS_CTRL:   grp_en   <= acc.data[0];
                OFS_ENABLE: ctr_en   <= acc.data[NCTR-1:0];
                OFS_MASK:   irq_mask <= acc.data[NCTR-1:0];
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NCTR; g++) begin : g_sel
        always_ff @(posedge clk) begin
            if (rst)
                sel[g] <= '1;
            else if (acc.wr && acc.addr == sel_reg_addr(g, PER))
                sel[g] <= acc.data[EW*(g%PER) +: EW];
        end
    end

    // R3: the second field of the first selector register lands in counter 1
    assert_sel_field_R3: assert property (@(posedge clk) disable iff (rst)
        (acc.wr && acc.addr == OFS_SEL0) |=> sel[1] == $past(acc.data[2*EW-1:EW]));

    // R12 / R5: a write to the version slot leaves the group enable untouched
    assert_ver_ro_R12: assert property (@(posedge clk) disable iff (rst)
        (acc.wr && acc.addr == OFS_VER) |=> $stable(grp_en));

endmodule

// File: rtl/upmu_ctr.sv
module upmu_ctr #(
    parameter int CW   = 48,
    parameter int EW   = 8,
    parameter int NEVT = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [EW-1:0]    code,
    input  logic [NEVT-1:0]  evt,
    input  logic             ld,
    input  logic [CW-1:0]    ld_val,
    output logic [CW-1:0]    cnt,
    output logic             wrap
);
    localparam logic [EW-1:0] CODE_NONE = '1;
    localparam logic [CW-1:0] CNT_TOP   = '1;

    logic hit;
    assign hit  = active && (code != CODE_NONE) && evt[code];
    assign wrap = hit && !ld && (cnt == CNT_TOP);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (ld)
            cnt <= ld_val;
        else if (hit)
            cnt <= cnt + 1'b1;
    end

    assert_load_wins_R11: assert property (@(posedge clk) disable iff (rst)
        ld |=> cnt == $past(ld_val));

    assert_none_code_R4: assert property (@(posedge clk) disable iff (rst)
        (code == CODE_NONE && !ld) |=> $stable(cnt));

    // R5 and R6 reach this block through active
    assert_gated_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!active && !ld) |=> $stable(cnt));

    assert_step_one_R7: assert property (@(posedge clk) disable iff (rst)
        (active && code != CODE_NONE && evt[code] && !ld && cnt != CNT_TOP)
        |=> cnt == $past(cnt) + 1'b1);

endmodule

// File: rtl/upmu_ovf.sv
module upmu_ovf #(
    parameter int NCTR = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NCTR-1:0] wrap,
    input  logic            clr_wr,
    input  logic [NCTR-1:0] clr_bits,
    input  logic [NCTR-1:0] mask,
    output logic [NCTR-1:0] status,
    output logic            irq
);
    logic [NCTR-1:0] clr_eff;
    assign clr_eff = clr_wr ? clr_bits : '0;

    always_ff @(posedge clk) begin
        if (rst)
            status <= '0;
        else
            status <= (status & ~clr_eff) | wrap;
    end

    assign irq = |(status & ~mask);

    assert_wrap_sets_R8: assert property (@(posedge clk) disable iff (rst)
        (|wrap) |=> (status & $past(wrap)) == $past(wrap));

    assert_w1c_R9: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> (status & $past(clr_bits & ~wrap)) == '0);

endmodule

// File: rtl/upmu_top.sv
module upmu_top
    import upmu_pkg::*;
#(
    parameter int          NCTR    = 16,
    parameter int          CW      = 48,
    parameter int          EW      = 8,
    parameter logic [31:0] VERSION = 32'h0001_0300
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [15:0]          addr,
    input  logic [63:0]          wdata,
    input  logic [(1<<EW)-1:0]   evt_pulse,
    output logic [63:0]          rdata,
    output logic                 irq
);
    localparam int NEVT = 1 << EW;
    localparam int PER  = SEL_REG_BITS / EW;

    reg_access_t     acc;
    logic            grp_en;
    logic [NCTR-1:0] ctr_en;
    logic [NCTR-1:0] irq_mask;
    logic [EW-1:0]   sel [NCTR];
    logic [CW-1:0]   cnt [NCTR];
    logic [NCTR-1:0] wrap;
    logic [NCTR-1:0] status;
    logic [63:0]     rd_mux;

    assign acc = '{wr: wr_en, rd: rd_en, addr: addr, data: wdata};

    upmu_cfg #(.NCTR(NCTR), .EW(EW)) cfg_i (
        .clk(clk), .rst(rst), .acc(acc),
        .grp_en(grp_en), .ctr_en(ctr_en), .irq_mask(irq_mask), .sel(sel)
    );

    for (genvar g = 0; g < NCTR; g++) begin : g_ctr
        logic ld;
        assign ld = acc.wr && acc.addr == cnt_slot_addr(g);
        upmu_ctr #(.CW(CW), .EW(EW), .NEVT(NEVT)) ctr_i (
            .clk(clk), .rst(rst),
            .active(grp_en && ctr_en[g]),
            .code(sel[g]), .evt(evt_pulse),
            .ld(ld), .ld_val(acc.data[CW-1:0]),
            .cnt(cnt[g]), .wrap(wrap[g])
        );
    end

    upmu_ovf #(.NCTR(NCTR)) ovf_i (
        .clk(clk), .rst(rst), .wrap(wrap),
        .clr_wr(acc.wr && acc.addr == OFS_CLEAR),
        .clr_bits(acc.data[NCTR-1:0]),
        .mask(irq_mask), .status(status), .irq(irq)
    );

    always_comb begin
        rd_mux = '0;
        case (acc.addr)
            OFS_MASK:   rd_mux[NCTR-1:0] = irq_mask;
            OFS_STATUS: rd_mux[NCTR-1:0] = status;
            OFS_VER:    rd_mux[31:0]     = VERSION;
            OFS_CTRL:   rd_mux[0]        = grp_en;
            OFS_ENABLE: rd_mux[NCTR-1:0] = ctr_en;
            default: ;
        endcase
        for (int i = 0; i < NCTR; i++) begin
            if (acc.addr == sel_reg_addr(i, PER))
                rd_mux[EW*(i%PER) +: EW] = sel[i];
            if (acc.addr == cnt_slot_addr(i))
                rd_mux[CW-1:0] = cnt[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else
            rdata <= acc.rd ? rd_mux : '0;
    end

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr >= OFS_CNT0) |=> rdata[63:CW] == '0);

    assert_idle_rdata_R13: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> rdata == '0);

    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (rst)
        (irq_mask == '1) |-> !irq);

endmodule

// File: tb/upmu_top_tb_top.sv
`timescale 1ns/1ps
module upmu_top_tb_top;
    localparam logic [31:0] VER = 32'h0001_0300;
    localparam logic [47:0] TOP = 48'hFFFF_FFFF_FFFF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [15:0] addr = '0;
    logic [63:0] wdata = '0;
    logic [255:0] evt = '0;
    logic [63:0] rdata;
    logic irq;

    always #2.5 clk = ~clk;

    upmu_top #(.VERSION(VER)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .evt_pulse(evt), .rdata(rdata), .irq(irq)
    );

    // reference state
    logic [47:0] m_cnt [16];
    logic [7:0]  m_sel [16];
    logic [15:0] m_en, m_mask, m_stat;
    logic        m_gen;
    logic [63:0] exp_rd;
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    function automatic logic [63:0] model_read(logic [15:0] a);
        logic [63:0] v = '0;
        case (a)
            16'h0804: v[15:0] = m_mask;
            16'h0808: v[15:0] = m_stat;
            16'h1CF0: v[31:0] = VER;
            16'h1E00: v[0]    = m_gen;
            16'h1E04: v[15:0] = m_en;
            default: ;
        endcase
        for (int n = 0; n < 16; n++) begin
            if (a == 16'h1E80 + 16'(4*(n/4))) v[8*(n%4) +: 8] = m_sel[n];
            if (a == 16'h1F00 + 16'(8*n)) v[47:0] = m_cnt[n];
        end
        return v;
    endfunction

    task automatic model_step(bit w, logic [15:0] a, logic [63:0] d, logic [255:0] e);
        logic [15:0] wr_set = '0;
        logic [15:0] clr = '0;
        for (int n = 0; n < 16; n++) begin
            bit inc = m_gen && m_en[n] && m_sel[n] != 8'hFF && e[m_sel[n]];
            if (w && a == 16'h1F00 + 16'(8*n)) m_cnt[n] = d[47:0];
            else if (inc) begin
                if (m_cnt[n] == TOP) wr_set[n] = 1'b1;
                m_cnt[n] = m_cnt[n] + 1'b1;
            end
        end
        if (w) begin
            if (a == 16'h080C) clr = d[15:0];
            if (a == 16'h0804) m_mask = d[15:0];
            if (a == 16'h1E00) m_gen = d[0];
            if (a == 16'h1E04) m_en = d[15:0];
            for (int n = 0; n < 16; n++)
                if (a == 16'h1E80 + 16'(4*(n/4))) m_sel[n] = d[8*(n%4) +: 8];
        end
        m_stat = (m_stat & ~clr) | wr_set;
    endtask

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(bit w, bit r, logic [15:0] a, logic [63:0] d, logic [255:0] e);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d; evt = e;
        exp_rd = model_read(a);
        model_step(w, a, d, e);
        @(posedge clk); #1;
        wr_en = 0; rd_en = 0; evt = '0;
        chk("R10 irq", {63'b0, irq}, {63'b0, |(m_stat & ~m_mask)});
    endtask

    task automatic wr(logic [15:0] a, logic [63:0] d);
        cyc(1, 0, a, d, '0);
    endtask

    task automatic rd_chk(string req, logic [15:0] a);
        cyc(0, 1, a, '0, '0);
        chk(req, rdata, exp_rd);
    endtask

    function automatic logic [255:0] one_evt(int c);
        logic [255:0] v = '0;
        v[c] = 1'b1;
        return v;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int n = 0; n < 16; n++) begin m_cnt[n] = '0; m_sel[n] = 8'hFF; end
        m_en = '0; m_mask = 16'hFFFF; m_stat = '0; m_gen = 0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset values, compared against constants
        cyc(0, 1, 16'h0804, '0, '0); chk("R1 mask", rdata, 64'hFFFF);
        cyc(0, 1, 16'h1E8C, '0, '0); chk("R1 sel", rdata, 64'hFFFF_FFFF);
        cyc(0, 1, 16'h1F28, '0, '0); chk("R1 cnt5", rdata, 64'h0);
        cyc(0, 1, 16'h0808, '0, '0); chk("R1 status", rdata, 64'h0);
        chk("R1 irq", {63'b0, irq}, 64'h0);

        // R12 version read-only
        cyc(0, 1, 16'h1CF0, '0, '0); chk("R12 version", rdata, {32'b0, VER});
        wr(16'h1CF0, 64'h1234_5678);
        cyc(0, 1, 16'h1CF0, '0, '0); chk("R12 after write", rdata, {32'b0, VER});

        // R3 selector placement, R7 counting
        wr(16'h1E00, 64'h1); wr(16'h1E04, 64'hFFFF);
        wr(16'h1E84, 64'h0302_0100);
        repeat (3) cyc(0, 0, '0, '0, one_evt(2));
        cyc(0, 1, 16'h1F30, '0, '0); chk("R3 R7 cnt6", rdata, 64'd3);
        cyc(0, 1, 16'h1F20, '0, '0); chk("R3 cnt4", rdata, 64'd0);
        cyc(0, 1, 16'h1E84, '0, '0); chk("R3 sel read", rdata, 64'h0302_0100);

        // R2 upper bits dropped
        wr(16'h1F48, 64'hFFFF_1234_5678_9ABC);
        cyc(0, 1, 16'h1F48, '0, '0); chk("R2 cnt9", rdata, 64'h0000_1234_5678_9ABC);

        // R8 wrap, R10 mask, R9 clear
        wr(16'h1F30, {16'hFFFF, 48'hFFFF_FFFF_FFFE});
        repeat (2) cyc(0, 0, '0, '0, one_evt(2));
        cyc(0, 1, 16'h1F30, '0, '0); chk("R8 cnt wrapped", rdata, 64'd0);
        cyc(0, 1, 16'h0808, '0, '0); chk("R8 status", rdata, 64'h40);
        chk("R10 masked", {63'b0, irq}, 64'h0);
        wr(16'h0804, 64'hFFBF);
        chk("R10 unmasked", {63'b0, irq}, 64'h1);
        wr(16'h080C, 64'h40);
        cyc(0, 1, 16'h0808, '0, '0); chk("R9 cleared", rdata, 64'h0);
        cyc(0, 1, 16'h080C, '0, '0); chk("R9 clear reads 0", rdata, 64'h0);
        // R9 wrap and clear in one cycle: set wins
        wr(16'h1F30, {16'h0, TOP});
        cyc(1, 0, 16'h080C, 64'h40, one_evt(2));
        cyc(0, 1, 16'h0808, '0, '0); chk("R9 set wins", rdata, 64'h40);
        wr(16'h080C, 64'hFFFF);

        // R11 write beats increment, no wrap
        wr(16'h1F30, {16'h0, TOP});
        cyc(1, 0, 16'h1F30, 64'd100, one_evt(2));
        cyc(0, 1, 16'h1F30, '0, '0); chk("R11 write wins", rdata, 64'd100);
        cyc(0, 1, 16'h0808, '0, '0); chk("R11 no status", rdata, 64'h0);

        // R5 group enable off
        wr(16'h1E00, 64'h0);
        repeat (3) cyc(0, 0, '0, '0, one_evt(2));
        cyc(0, 1, 16'h1F30, '0, '0); chk("R5 hold", rdata, 64'd100);
        wr(16'h1E00, 64'h1);
        // R6 per-counter enable off
        wr(16'h1E04, 64'hFFBF);
        repeat (3) cyc(0, 0, '0, '0, one_evt(2));
        cyc(0, 1, 16'h1F30, '0, '0); chk("R6 hold", rdata, 64'd100);
        wr(16'h1E04, 64'hFFFF);

        // R4 code 0xFF ignores all events
        repeat (2) cyc(0, 0, '0, '0, '1);
        cyc(0, 1, 16'h1F00, '0, '0); chk("R4 cnt0", rdata, 64'd0);
        rd_chk("R7 cnt5 all events", 16'h1F28);

        // R13 unmapped read
        cyc(0, 1, 16'h0100, '0, '0); chk("R13 unmapped", rdata, 64'h0);

        // random phase
        for (int k = 0; k < 4; k++)
            wr(16'h1E80 + 16'(4*k), {32'b0, $urandom() & 32'h0707_0707 | (($urandom()%4==0) ? 32'hFF : 32'h0)});
        for (int it = 0; it < 6000; it++) begin
            int op = $urandom() % 20;
            logic [255:0] e = '0;
            for (int c = 0; c < 8; c++) e[c] = ($urandom() % 3 == 0);
            if ($urandom() % 16 == 0) e = {$urandom(), $urandom(), $urandom(), $urandom(),
                                            $urandom(), $urandom(), $urandom(), $urandom()};
            if (op == 0) begin
                int n = $urandom() % 16;
                cyc(1, 0, 16'h1F00 + 16'(8*n),
                    {16'($urandom()), 40'hFF_FFFF_FFFF, 8'hF0 | 8'($urandom())}, e);
            end else if (op == 1) cyc(1, 0, 16'h080C, 64'($urandom()), e);
            else if (op == 2) cyc(1, 0, 16'h0804, 64'($urandom()), e);
            else if (op == 3 && $urandom() % 4 == 0) cyc(1, 0, 16'h1E04, 64'($urandom() | 32'hF0F0), e);
            else if (op == 4 && $urandom() % 8 == 0) cyc(1, 0, 16'h1E00, 64'($urandom() % 4 != 0), e);
            else if (op == 5 || op == 6) begin
                int n = $urandom() % 16;
                cyc(0, 1, 16'h1F00 + 16'(8*n), '0, e);
                chk("R7 R8 random cnt", rdata, exp_rd);
            end else if (op == 7) begin
                cyc(0, 1, 16'h0808, '0, e);
                chk("R8 R9 random status", rdata, exp_rd);
            end else cyc(0, 0, '0, '0, e);
        end
        for (int n = 0; n < 16; n++) rd_chk("R7 final cnt", 16'h1F00 + 16'(8*n));

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule